// File: doc/BRIEF.md
# Compact-to-IPv6 Header Expander

This block sits where a data-center fabric meets the wide-area network. Each packet arrives as a parsed compact header descriptor, followed by a stream of payload bytes. The descriptor carries the traffic class, the flow label, the next-header value, a 4-bit hop limit, two 4-bit address length codes, the source and destination addresses, and the link-layer frame length. The block turns each packet into a standard 40-byte IPv6 fixed header, sent one byte per beat, and then forwards the payload bytes unchanged on the same output stream.

The fabric omits some IPv6 fields because the link layer implies them. The block rebuilds these: the version is a constant, and the payload length comes from the frame length. Short hierarchical addresses are grown back to 128 bits. The low bytes come from the packet and the high bytes from a per-direction prefix input, so no address information is lost. A length code of N (1 to 15) means an N-byte address, and code 0 means a full 16-byte address. The compact header on the wire occupies 6 + source bytes + destination bytes, rounded up to a multiple of four.

Both the descriptor input and the payload input use a valid/ready handshake, and so does the output byte stream. Backpressure on the output holds every stage, and no byte is lost or repeated.

Top module: `hdr_expander`

## Requirements
- R1: Output byte 0 is {4'h6, tclass[7:4]}, byte 1 is {tclass[3:0], flow[19:16]}, and bytes 2 and 3 are flow[15:8] and flow[7:0].
- R2: Output byte 6 is the next-header value unchanged, and byte 7 is the 4-bit hop limit zero-extended to 8 bits.
- R3: Bytes 4 and 5 (high byte first) carry frame length minus ceil4(6 + Sb + Db). Here Sb and Db are the address byte counts, code N giving N bytes and code 0 giving 16.
- R4: When the frame length is smaller than that padded header length, the payload length field is 0.
- R5: An address whose code is 0 is sent as its 128 input bits unchanged.
- R6: An address with code N in 1..15 keeps its low N bytes from the input. Its upper 16−N bytes come from the upper bytes of the prefix, and input address bits above the low N bytes have no effect.
- R7: The source address fills bytes 8–23 using the source prefix. The destination address fills bytes 24–39 using the destination prefix.
- R8: After the 40 header bytes, the payload bytes follow unmodified and in order. The output last flag is set on the byte that carried the input last flag.
- R9: When the derived payload length is 0, the packet ends with last on header byte 39, and no payload input byte is accepted for it.
- R10: While the output is valid and not ready, the output data and last flag hold their values. No byte is dropped or duplicated under any stall pattern.
- R11: A new descriptor is accepted only when no packet is in flight. After an acceptance, the descriptor ready signal stays low until the last output byte of that packet is taken.
- R12: After reset the output is not valid and the descriptor ready signal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_prefix | input | 128 | Prefix that supplies the upper bytes of short source addresses |
| dst_prefix | input | 128 | Prefix that supplies the upper bytes of short destination addresses |
| hdr_valid | input | 1 | Descriptor valid |
| hdr_ready | output | 1 | Descriptor accepted when high together with hdr_valid |
| hdr_tclass | input | 8 | Traffic class |
| hdr_flow | input | 20 | Flow label |
| hdr_next | input | 8 | Next-header value |
| hdr_hops | input | 4 | Compact hop limit |
| hdr_scode | input | 4 | Source address length code |
| hdr_dcode | input | 4 | Destination address length code |
| hdr_saddr | input | 128 | Source address, short form in the low bytes |
| hdr_daddr | input | 128 | Destination address, short form in the low bytes |
| hdr_flen | input | LEN_W | Link-layer frame length in bytes |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Final payload byte of the packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the output packet |

## Verification
A table of packets covers several code pairs: both addresses short and equal, short with full, full with full, and the extreme codes 15 and 1. Equal short codes show that prefix widening is correct. Mixed and full codes show that code 0 bypasses the prefix and that each direction uses its own prefix. Frame lengths are chosen so that some padded headers round up and others do not, which exercises the payload length arithmetic. Two further entries have exactly zero and negative remaining length, and these exercise the header-only end of packet and the clamp. Address inputs hold nonzero bytes above the short length to show that those bytes are ignored. Output stall patterns vary between packets to show that backpressure holds the data and keeps the byte count exact.

// File: rtl/hdr_expander_pkg.sv
package hdr_expander_pkg;

    localparam int ADDR_BYTES = 16;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int HDR_BYTES  = 40;
    localparam int HDR_W      = HDR_BYTES * 8;
    localparam int CODE_W     = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HDR  = 2'd1,
        SEQ_PAY  = 2'd2
    } seq_state_e;

    // Byte count carried by an address length code; zero selects a full address.
    function automatic logic [4:0] code_bytes(input logic [CODE_W-1:0] code);
        return (code == '0) ? 5'(ADDR_BYTES) : 5'(code);
    endfunction

endpackage

// File: rtl/hdr_addr_widen.sv
module hdr_addr_widen
    import hdr_expander_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES
) (
    input  logic [CODE_W-1:0]   code,
    input  logic [NBYTES*8-1:0] addr,
    input  logic [NBYTES*8-1:0] prefix,
    output logic [NBYTES*8-1:0] wide
);

    // Byte j counts from the least significant end: low bytes come from the
    // packet, the remaining upper bytes from the prefix.
    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        logic keep;
        assign keep = (code == '0) || (j < int'(code));
        assign wide[j*8 +: 8] = keep ? addr[j*8 +: 8] : prefix[j*8 +: 8];
    end

endmodule

// File: rtl/hdr_field_pack.sv
module hdr_field_pack
    import hdr_expander_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [7:0]        tclass,
    input  logic [19:0]       flow,
    input  logic [7:0]        next_hdr,
    input  logic [3:0]        hops,
    input  logic [CODE_W-1:0] scode,
    input  logic [CODE_W-1:0] dcode,
    input  logic [LEN_W-1:0]  flen,
    input  logic [ADDR_W-1:0] src_wide,
    input  logic [ADDR_W-1:0] dst_wide,
    output logic [HDR_W-1:0]  hdr_vec,
    output logic              pay_empty
);

    localparam int SUM_W = 7;

    logic [SUM_W-1:0] raw_len;
    logic [SUM_W-1:0] pad_len;
    logic [LEN_W-1:0] pad_ext;
    logic [LEN_W-1:0] pay_len;
    logic [15:0]      pay_field;

    always_comb begin
        raw_len   = SUM_W'(6) + SUM_W'(code_bytes(scode)) + SUM_W'(code_bytes(dcode));
        pad_len   = (raw_len + SUM_W'(3)) & ~SUM_W'(3);
        pad_ext   = LEN_W'(pad_len);
        pay_len   = (flen >= pad_ext) ? (flen - pad_ext) : '0;
        pay_field = 16'(pay_len);
        pay_empty = (pay_len == '0);
        hdr_vec   = {4'h6, tclass, flow, pay_field, next_hdr, 4'h0, hops,
                     src_wide, dst_wide};
    end

endmodule

// File: rtl/hdr_emit_seq.sv
module hdr_emit_seq
    import hdr_expander_pkg::*;
#(
    parameter int NBYTES = HDR_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hdr_valid,
    output logic                hdr_ready,
    input  logic [NBYTES*8-1:0] hdr_vec,
    input  logic                hdr_empty,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [7:0]          in_data,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [7:0]          out_data,
    output logic                out_last
);

    localparam int VW    = NBYTES * 8;
    localparam int CNT_W = $clog2(NBYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [VW-1:0]    sh;
        logic             empty;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        hdr_ready = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                hdr_ready = 1'b1;
                if (hdr_valid) begin
                    seq_d.st    = SEQ_HDR;
                    seq_d.cnt   = '0;
                    seq_d.sh    = hdr_vec;
                    seq_d.empty = hdr_empty;
                end
            end
            SEQ_HDR: begin
                out_valid = 1'b1;
                out_data  = seq_q.sh[VW-1 -: 8];
                out_last  = seq_q.empty && (seq_q.cnt == LAST_IDX);
                if (out_ready) begin
                    seq_d.sh  = seq_q.sh << 8;
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                    if (seq_q.cnt == LAST_IDX) begin
                        seq_d.st = seq_q.empty ? SEQ_IDLE : SEQ_PAY;
                    end
                end
            end
            SEQ_PAY: begin
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = in_last;
                in_ready  = out_ready;
                if (in_valid && out_ready && in_last) begin
                    seq_d.st = SEQ_IDLE;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= SEQ_IDLE;
            seq_q.cnt   <= '0;
            seq_q.sh    <= '0;
            seq_q.empty <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/hdr_expander.sv
module hdr_expander
    import hdr_expander_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [127:0]      src_prefix,
    input  logic [127:0]      dst_prefix,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [7:0]        hdr_tclass,
    input  logic [19:0]       hdr_flow,
    input  logic [7:0]        hdr_next,
    input  logic [3:0]        hdr_hops,
    input  logic [3:0]        hdr_scode,
    input  logic [3:0]        hdr_dcode,
    input  logic [127:0]      hdr_saddr,
    input  logic [127:0]      hdr_daddr,
    input  logic [LEN_W-1:0]  hdr_flen,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last
);

    logic [ADDR_W-1:0] src_wide;
    logic [ADDR_W-1:0] dst_wide;
    logic [HDR_W-1:0]  hdr_vec;
    logic              pay_empty;

    hdr_addr_widen #(.NBYTES(ADDR_BYTES)) u_src_widen (
        .code   (hdr_scode),
        .addr   (hdr_saddr),
        .prefix (src_prefix),
        .wide   (src_wide)
    );

    hdr_addr_widen #(.NBYTES(ADDR_BYTES)) u_dst_widen (
        .code   (hdr_dcode),
        .addr   (hdr_daddr),
        .prefix (dst_prefix),
        .wide   (dst_wide)
    );

    hdr_field_pack #(.LEN_W(LEN_W)) u_pack (
        .tclass    (hdr_tclass),
        .flow      (hdr_flow),
        .next_hdr  (hdr_next),
        .hops      (hdr_hops),
        .scode     (hdr_scode),
        .dcode     (hdr_dcode),
        .flen      (hdr_flen),
        .src_wide  (src_wide),
        .dst_wide  (dst_wide),
        .hdr_vec   (hdr_vec),
        .pay_empty (pay_empty)
    );

    hdr_emit_seq #(.NBYTES(HDR_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .hdr_ready (hdr_ready),
        .hdr_vec   (hdr_vec),
        .hdr_empty (pay_empty),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: rtl/hdr_expander_chk.sv
module hdr_expander_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hdr_valid,
    input logic       hdr_ready,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       in_last,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last
);

    logic [15:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (out_valid && out_ready) begin
            pos_q <= out_last ? 16'd0 : ((pos_q == 16'hFFFF) ? pos_q : pos_q + 16'd1);
        end
    end

    // R1
    ver_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && pos_q == 16'd0 |-> out_data[7:4] == 4'h6);

    // R2
    hop_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && pos_q == 16'd7 |-> out_data[7:4] == 4'h0);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R8
    last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> pos_q >= 16'd39);

    // R8
    pay_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> out_valid && out_ready && out_data == in_data
                                 && out_last == in_last);

    // R9
    pay_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> pos_q >= 16'd40);

    // R11
    one_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready |=> !hdr_ready);

endmodule

bind hdr_expander hdr_expander_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/hdr_expander_test.sv
`timescale 1ns/1ps
module hdr_expander_test;

    typedef struct packed {
        logic [7:0]  tc;
        logic [19:0] fl;
        logic [7:0]  nh;
        logic [3:0]  hop;
        logic [3:0]  sc;
        logic [3:0]  dc;
        logic [15:0] flen;
        logic [15:0] plen;
        logic [1:0]  stall;
        logic [1:0]  kind;   // 0 normal, 1 exact zero payload, 2 clamped
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'hB7, 20'hABCDE, 8'h11, 4'h5, 4'd1,  4'd1,  16'd12, 16'd4, 2'd0, 2'd0},
        '{8'h2C, 20'h12345, 8'h06, 4'hF, 4'd2,  4'd2,  16'd17, 16'd5, 2'd1, 2'd0},
        '{8'h00, 20'hFFFFF, 8'h3A, 4'h1, 4'd3,  4'd3,  16'd15, 16'd3, 2'd2, 2'd0},
        '{8'hFF, 20'h00001, 8'h2B, 4'h0, 4'd4,  4'd4,  16'd22, 16'd6, 2'd0, 2'd0},
        '{8'h5A, 20'h5A5A5, 8'h11, 4'h7, 4'd4,  4'd0,  16'd30, 16'd2, 2'd1, 2'd0},
        '{8'h81, 20'h80001, 8'h3B, 4'h9, 4'd0,  4'd0,  16'd43, 16'd3, 2'd2, 2'd0},
        '{8'h3C, 20'h0F0F0, 8'h11, 4'h3, 4'd15, 4'd1,  16'd24, 16'd0, 2'd1, 2'd1},
        '{8'hC3, 20'hF0F0F, 8'h06, 4'h2, 4'd1,  4'd7,  16'd10, 16'd0, 2'd0, 2'd2},
        '{8'h96, 20'h69696, 8'h32, 4'hE, 4'd0,  4'd15, 16'd41, 16'd1, 2'd2, 2'd0}
    };

    localparam logic [127:0] SPFX = 128'h20010DB8_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF;
    localparam logic [127:0] DPFX = 128'hFD00_1122_3344_5566_7788_99AA_BBCC_DDEE;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hdr_valid = 1'b0;
    logic         hdr_ready;
    logic [7:0]   hdr_tclass = '0;
    logic [19:0]  hdr_flow = '0;
    logic [7:0]   hdr_next = '0;
    logic [3:0]   hdr_hops = '0;
    logic [3:0]   hdr_scode = '0;
    logic [3:0]   hdr_dcode = '0;
    logic [127:0] hdr_saddr = '0;
    logic [127:0] hdr_daddr = '0;
    logic [15:0]  hdr_flen = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_data = '0;
    logic         in_last = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [7:0]   out_data;
    logic         out_last;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    hdr_expander #(.LEN_W(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .src_prefix(SPFX), .dst_prefix(DPFX),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_tclass(hdr_tclass), .hdr_flow(hdr_flow), .hdr_next(hdr_next),
        .hdr_hops(hdr_hops), .hdr_scode(hdr_scode), .hdr_dcode(hdr_dcode),
        .hdr_saddr(hdr_saddr), .hdr_daddr(hdr_daddr), .hdr_flen(hdr_flen),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mkaddr(input int seed);
        logic [127:0] a;
        for (int k = 0; k < 16; k++) a[k*8 +: 8] = 8'(seed * 29 + k * 13 + 7);
        return a;
    endfunction

    // Expected widened address: low N bytes from packet, the rest from prefix (R5, R6).
    function automatic logic [127:0] grow(input logic [3:0] code, input logic [127:0] a,
                                          input logic [127:0] p);
        logic [127:0] r;
        for (int j = 0; j < 16; j++)
            r[j*8 +: 8] = (code == 4'd0 || j < int'(code)) ? a[j*8 +: 8] : p[j*8 +: 8];
        return r;
    endfunction

    function automatic logic [7:0] pay_byte(input int v, input int k);
        return 8'(8'h5A ^ (v * 16 + k * 3));
    endfunction

    task automatic run_vec(input int i);
        vec_t         v;
        logic [127:0] sa, da, esa, eda, gsa, gda;
        logic [7:0]   got [128];
        logic [7:0]   exh [40];
        logic [7:0]   prev;
        int n, lastpos, pidx, cyc, junk, bad_pay;
        bit hdr_done, early, hold_err, prev_stall, rdy;
        string tag_len;
        v = VEC[i];
        sa = mkaddr(i * 2 + 1);
        da = mkaddr(i * 2 + 2);
        esa = grow(v.sc, sa, SPFX);
        eda = grow(v.dc, da, DPFX);
        exh[0] = {4'h6, v.tc[7:4]};
        exh[1] = {v.tc[3:0], v.fl[19:16]};
        exh[2] = v.fl[15:8];
        exh[3] = v.fl[7:0];
        exh[4] = v.plen[15:8];
        exh[5] = v.plen[7:0];
        exh[6] = v.nh;
        exh[7] = {4'h0, v.hop};
        n = 0; lastpos = -1; pidx = 0; cyc = 0; junk = 0; bad_pay = 0;
        hdr_done = 0; early = 0; hold_err = 0; prev_stall = 0; prev = '0;
        for (int k = 0; k < 128; k++) got[k] = '0;
        @(negedge clk);
        hdr_tclass = v.tc; hdr_flow = v.fl; hdr_next = v.nh; hdr_hops = v.hop;
        hdr_scode = v.sc; hdr_dcode = v.dc; hdr_flen = v.flen;
        hdr_saddr = sa; hdr_daddr = da;
        while (lastpos < 0 && cyc < 3000) begin
            if (cyc > 0) @(negedge clk);
            hdr_valid = !hdr_done;
            case (v.stall)
                2'd1:    rdy = (cyc % 2) == 0;
                2'd2:    rdy = (cyc % 3) == 0;
                default: rdy = 1'b1;
            endcase
            out_ready = rdy;
            if (pidx < int'(v.plen)) begin
                in_valid = 1'b1; in_data = pay_byte(i, pidx);
                in_last = (pidx == int'(v.plen) - 1);
            end else if (v.plen == 16'd0) begin
                in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1;
            end else begin
                in_valid = 1'b0; in_last = 1'b0;
            end
            #1;
            if (prev_stall && out_data !== prev) hold_err = 1;
            prev_stall = out_valid && !out_ready;
            prev = out_data;
            if (hdr_done && hdr_ready) early = 1;
            if (hdr_valid && hdr_ready) hdr_done = 1;
            if (out_valid && out_ready) begin
                if (n < 128) got[n] = out_data;
                if (out_last) lastpos = n;
                n++;
            end
            if (in_valid && in_ready) begin
                if (pidx < int'(v.plen)) pidx++;
                else junk++;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; hdr_valid = 1'b0; out_ready = 1'b0;

        chk(lastpos == 39 + int'(v.plen), (v.plen == 0) ? "R9 end" : "R8 end",
            128'(lastpos), 128'(39 + int'(v.plen)));
        chk({got[0], got[1], got[2], got[3]} == {exh[0], exh[1], exh[2], exh[3]}, "R1",
            {got[0], got[1], got[2], got[3]}, {exh[0], exh[1], exh[2], exh[3]});
        tag_len = (v.kind == 2'd2) ? "R4" : "R3";
        chk({got[4], got[5]} == v.plen, tag_len, {got[4], got[5]}, v.plen);
        chk({got[6], got[7]} == {exh[6], exh[7]}, "R2", {got[6], got[7]}, {exh[6], exh[7]});
        for (int k = 0; k < 16; k++) begin
            gsa[127 - k*8 -: 8] = got[8 + k];
            gda[127 - k*8 -: 8] = got[24 + k];
        end
        if (v.sc == 4'd0) chk(gsa == esa, "R5 src", gsa, esa);
        else              chk(gsa == esa, "R6 src", gsa, esa);
        chk(gda == eda, "R7 dst", gda, eda);
        for (int k = 0; k < int'(v.plen); k++)
            if (got[40 + k] !== pay_byte(i, k)) bad_pay++;
        if (v.plen != 0) chk(bad_pay == 0, "R8 payload", 128'(bad_pay), 128'd0);
        else             chk(junk == 0, "R9 no payload taken", 128'(junk), 128'd0);
        chk(!hold_err && n == 40 + int'(v.plen), "R10", 128'(n), 128'(40 + int'(v.plen)));
        chk(!early, "R11", 128'(early), 128'd0);
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0 && hdr_ready == 1'b1, "R12 in reset",
            {out_valid, hdr_ready}, 2'b01);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0 && hdr_ready == 1'b1, "R12 after reset",
            {out_valid, hdr_ready}, 2'b01);
        for (int i = 0; i < NV; i++) run_vec(i);
        // Directed: reset in the middle of a header returns to idle (R12).
        @(negedge clk);
        hdr_scode = 4'd1; hdr_dcode = 4'd1; hdr_flen = 16'd20; hdr_valid = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        hdr_valid = 1'b0;
        #1;
        chk(out_valid == 1'b1 && hdr_ready == 1'b0, "R11 busy",
            {out_valid, hdr_ready}, 2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0 && hdr_ready == 1'b1, "R12 mid packet",
            {out_valid, hdr_ready}, 2'b01);
        // Directed: the same descriptor after reset still yields version first byte (R1).
        run_vec(0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule